// File: doc/BRIEF.md
# Packed Complex Symmetric FIR Cascade

This block filters a stream of complex samples with 16-bit signed parts. Each 128-bit input beat holds four complex samples in consecutive time order. The block splits every beat into an in-phase lane and a quadrature lane. Each lane goes through a chain of identical linear-phase FIR stages. The two filtered lanes are then packed back into 128-bit output beats in the same layout as the input. The real and imaginary lanes never mix.

Each stage computes all four outputs of a beat in one clock. Because the taps are symmetric, the two samples that share a coefficient are added first and then multiplied once. The sum is kept at full precision. A fixed bit window of it becomes the 16-bit stage output, and that output drives the next stage.

Both sides use valid/ready flow control. The whole pipeline advances together and freezes together. A stall on the output therefore holds every stage without losing or repeating any sample. The tap count, the number of stages and the truncation shift are set at elaboration time. The coefficients are a fixed computed table.

Top module: `cfir_chain`

## Requirements
- R1: In every beat, sample slot k (k = 0..3) carries its imaginary part in bits [32k+15:32k] and its real part in bits [32k+31:32k+16]. Slot 0 is the earliest sample in time. Output beats use the same layout.
- R2: Each lane computes y[n] = sum over i of h[i]*x[n-i], with i running from 0 to NUM_TAPS-1. The taps are h[i] = 600*(m+1), negated when m is odd, where m = min(i, NUM_TAPS-1-i). Real and imaginary lanes are filtered independently and identically.
- R3: A stage output is bits [SHIFT+15:SHIFT] of the exact two's-complement sum, with SHIFT defaulting to 15. Lower bits are dropped without rounding and higher bits are discarded, so out-of-range values wrap.
- R4: NUM_STAGES stages (default 1) are cascaded. The 16-bit output of each stage is the input of the next, and every stage uses the same taps.
- R5: While m_ready is high, s_ready is high, so one beat per clock is accepted. An accepted beat appears on m_valid NUM_STAGES clock edges after it is accepted.
- R6: While m_valid is high and m_ready is low, m_valid and m_data hold their values and s_ready is low. Every accepted beat produces exactly one output beat, in order.
- R7: After reset, m_valid is low, s_ready is high, and every filter history holds zeros. The first outputs are therefore computed as if zeros came before the first sample.
- R8: Clock cycles without an accepted input beat do not advance any filter history. The output sequence depends only on the sequence of accepted beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Block accepts an input beat |
| s_data | input | 128 | Four packed complex input samples |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts an output beat |
| m_data | output | 128 | Four packed complex filtered samples |

## Verification
The two functions that can fall in the same cycle are the pipeline advance and the output stall. An input beat can be offered on exactly the edge where the held output is released, and gaps in the input stream can coincide with downstream backpressure. The bench provokes this by randomising s_valid and m_ready independently, with full-rate streaming phases and wrap-provoking extreme samples mixed in. It judges the result by matching every output beat, in order, against a per-sample model of the cascade, and by checking that a held output stays stable until it is taken.

// File: rtl/cfir_pkg.sv
package cfir_pkg;

  // Symmetric tap value for index i of an nt-tap filter.
  function automatic int tap_coef(input int i, input int nt);
    int m;
    int v;
    m = (i < nt - 1 - i) ? i : nt - 1 - i;
    v = 600 * (m + 1);
    return (m % 2 == 1) ? -v : v;
  endfunction

endpackage

// File: rtl/cfir_lane.sv
module cfir_lane #(
  parameter int NUM_TAPS = 15,
  parameter int SPB      = 4,
  parameter int DATA_W   = 16,
  parameter int COEF_W   = 16,
  parameter int SHIFT    = 15
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic [SPB-1:0][DATA_W-1:0]   x_in,
  output logic [SPB-1:0][DATA_W-1:0]   y_out
);
  localparam int HIST_N = NUM_TAPS - 1;
  localparam int EXT_N  = NUM_TAPS + SPB - 1;
  localparam int HALF   = NUM_TAPS / 2;
  localparam int ACC_W  = DATA_W + COEF_W + 2 + $clog2(NUM_TAPS);

  logic [HIST_N-1:0][DATA_W-1:0] hist_q, hist_d;
  logic [SPB-1:0][DATA_W-1:0]    y_q, y_d;
  logic signed [DATA_W-1:0]      ext [EXT_N];
  logic signed [DATA_W:0]        pre;
  logic signed [COEF_W-1:0]      cf;
  logic signed [ACC_W-1:0]       acc;

  // Next-state: folded symmetric multiply-accumulate for each slot
  always_comb begin
    for (int p = 0; p < HIST_N; p++) ext[HIST_N-1-p] = hist_q[p];
    for (int k = 0; k < SPB; k++)    ext[HIST_N+k]   = x_in[k];
    pre = '0;
    cf  = '0;
    acc = '0;
    for (int k = 0; k < SPB; k++) begin
      acc = '0;
      for (int i = 0; i < HALF; i++) begin
        pre = (DATA_W+1)'(ext[HIST_N+k-i]) + (DATA_W+1)'(ext[k+i]);
        cf  = COEF_W'(cfir_pkg::tap_coef(i, NUM_TAPS));
        acc = acc + ACC_W'(pre) * ACC_W'(cf);
      end
      if (NUM_TAPS % 2 == 1) begin
        pre = (DATA_W+1)'(ext[HIST_N+k-HALF]);
        cf  = COEF_W'(cfir_pkg::tap_coef(HALF, NUM_TAPS));
        acc = acc + ACC_W'(pre) * ACC_W'(cf);
      end
      y_d[k] = acc[SHIFT+DATA_W-1:SHIFT];
    end
    for (int p = 0; p < HIST_N; p++) hist_d[p] = ext[EXT_N-1-p];
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      y_q    <= '0;
    end else if (en) begin
      hist_q <= hist_d;
      y_q    <= y_d;
    end
  end

  assign y_out = y_q;

  AST_HIST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(hist_q) && $stable(y_q)); // R8

endmodule

// File: rtl/cfir_stage.sv
module cfir_stage #(
  parameter int NUM_TAPS = 15,
  parameter int SPB      = 4,
  parameter int DATA_W   = 16,
  parameter int COEF_W   = 16,
  parameter int SHIFT    = 15
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              adv,
  input  logic                              in_valid,
  input  logic [1:0][SPB-1:0][DATA_W-1:0]   in_lane,
  output logic                              out_valid,
  output logic [1:0][SPB-1:0][DATA_W-1:0]   out_lane
);
  logic lane_en;
  logic valid_q, valid_d;

  assign lane_en = adv && in_valid;

  // Lane 0 is imaginary, lane 1 is real; both share one structure
  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    cfir_lane #(
      .NUM_TAPS(NUM_TAPS), .SPB(SPB), .DATA_W(DATA_W),
      .COEF_W(COEF_W), .SHIFT(SHIFT)
    ) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (lane_en),
      .x_in (in_lane[ln]),
      .y_out(out_lane[ln])
    );
  end

  always_comb begin
    valid_d = valid_q;
    if (adv) valid_d = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign out_valid = valid_q;

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    adv && in_valid |=> out_valid); // R5
  AST_BUBBLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !in_valid |=> !out_valid); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(out_valid) && $stable(out_lane)); // R6

endmodule

// File: rtl/cfir_chain.sv
module cfir_chain #(
  parameter int NUM_TAPS   = 15,
  parameter int NUM_STAGES = 1,
  parameter int SPB        = 4,
  parameter int DATA_W     = 16,
  parameter int COEF_W     = 16,
  parameter int SHIFT      = 15,
  localparam int BUS_W     = SPB * 2 * DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [BUS_W-1:0] s_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [BUS_W-1:0] m_data
);
  localparam int SLOT_W = 2 * DATA_W;

  logic [1:0] rst_q;
  logic       rst_int;
  logic       adv;
  logic [NUM_STAGES:0]                            stg_v;
  logic [NUM_STAGES:0][1:0][SPB-1:0][DATA_W-1:0]  stg_d;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int = rst_q[1];

  // Single advance for the whole pipeline
  assign adv     = !stg_v[NUM_STAGES] || m_ready;
  assign s_ready = rst_int && adv;

  assign stg_v[0] = s_valid && rst_int;

  // Unpack / repack: imaginary low half, real high half of each slot
  for (genvar k = 0; k < SPB; k++) begin : g_slot
    assign stg_d[0][0][k] = s_data[SLOT_W*k +: DATA_W];
    assign stg_d[0][1][k] = s_data[SLOT_W*k + DATA_W +: DATA_W];
    assign m_data[SLOT_W*k +: DATA_W]          = stg_d[NUM_STAGES][0][k];
    assign m_data[SLOT_W*k + DATA_W +: DATA_W] = stg_d[NUM_STAGES][1][k];
  end

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    cfir_stage #(
      .NUM_TAPS(NUM_TAPS), .SPB(SPB), .DATA_W(DATA_W),
      .COEF_W(COEF_W), .SHIFT(SHIFT)
    ) u_stage (
      .clk      (clk),
      .rst_n    (rst_int),
      .adv      (adv),
      .in_valid (stg_v[s]),
      .in_lane  (stg_d[s]),
      .out_valid(stg_v[s+1]),
      .out_lane (stg_d[s+1])
    );
  end

  assign m_valid = stg_v[NUM_STAGES];

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_int)
    m_valid && !m_ready |=> m_valid && $stable(m_data)); // R6
  AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (!rst_int)
    m_valid && !m_ready |-> !s_ready); // R6

endmodule

// File: tb/sim_cfir_chain.sv
module sim_cfir_chain;
  localparam int NT = 15;
  localparam int NS = 1;
  localparam int SH = 15;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic [127:0] s_data = '0;
  logic         m_valid;
  logic         m_ready = 1'b0;
  logic [127:0] m_data;

  int checks = 0;
  int failures = 0;
  logic [127:0] expq[$];
  int  hist [NS][2][NT];
  bit  hold_pend = 0;
  logic [127:0] hold_data;
  bit  in_fire;

  always #10 clk = ~clk;

  cfir_chain #(.NUM_TAPS(NT), .NUM_STAGES(NS), .SHIFT(SH)) u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  function automatic int hcoef(int i);
    int m = (i < NT - 1 - i) ? i : NT - 1 - i;
    int v = 600 * (m + 1);
    return (m % 2 == 1) ? -v : v;
  endfunction

  function automatic logic [15:0] run(int st, int ln, logic [15:0] x);
    longint acc = 0;
    for (int i = NT - 1; i > 0; i--) hist[st][ln][i] = hist[st][ln][i-1];
    hist[st][ln][0] = int'($signed(x));
    for (int i = 0; i < NT; i++) acc += longint'(hcoef(i)) * longint'(hist[st][ln][i]);
    return 16'(acc >>> SH);
  endfunction

  function automatic logic [127:0] model(logic [127:0] d);
    logic [127:0] r;
    logic [15:0] v;
    for (int k = 0; k < 4; k++) begin
      for (int ln = 0; ln < 2; ln++) begin
        v = d[32*k + 16*ln +: 16];
        for (int st = 0; st < NS; st++) v = run(st, ln, v);
        r[32*k + 16*ln +: 16] = v;
      end
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit sv, logic [127:0] d, bit mr);
    logic [127:0] e;
    @(negedge clk);
    s_valid = sv; s_data = d; m_ready = mr;
    #1;
    if (hold_pend)
      check(m_valid === 1'b1 && m_data === hold_data, "R6 hold", m_data, hold_data);
    if (mr) check(s_ready === 1'b1, "R5 ready", 128'(s_ready), 128'(1));
    if (m_valid && m_ready) begin
      if (expq.size() == 0) check(0, "R6 extra beat", m_data, '0);
      else begin
        e = expq.pop_front();
        check(m_data === e, "R2 R3 R4 R8 data", m_data, e);
      end
    end
    hold_pend = m_valid && !m_ready;
    hold_data = m_data;
    in_fire = sv && s_ready;
    if (in_fire) expq.push_back(model(d));
  endtask

  function automatic logic [15:0] rnd16();
    int c = $urandom % 8;
    if (c == 0) return 16'h7FFF;
    if (c == 1) return 16'h8000;
    return 16'($urandom);
  endfunction

  function automatic logic [127:0] rndbeat();
    logic [127:0] b;
    bit ext = ($urandom % 4 == 0);
    for (int j = 0; j < 8; j++) b[16*j +: 16] = ext ? rnd16() : 16'($urandom);
    return b;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] b;
    bit have;
    int fires;
    void'($urandom(32'd4242));
    for (int s = 0; s < NS; s++)
      for (int l = 0; l < 2; l++)
        for (int i = 0; i < NT; i++) hist[s][l][i] = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R7: idle after reset
    check(m_valid === 1'b0, "R7 m_valid", 128'(m_valid), '0);
    check(s_ready === 1'b1, "R7 s_ready", 128'(s_ready), 128'(1));

    // R1 R5 R7: single real impulse, latency and lane placement
    b = '0; b[31:16] = 16'd1000;
    step(1, b, 1);
    check(in_fire, "R5 accept", 128'(in_fire), 128'(1));
    for (int k = 1; k <= NS; k++) begin
      @(negedge clk); s_valid = 0; m_ready = 0; #1;
      if (k < NS) check(m_valid === 1'b0, "R5 early", 128'(m_valid), '0);
      else begin
        check(m_valid === 1'b1, "R5 latency", 128'(m_valid), 128'(1));
        check(m_data[31:16] === 16'd18, "R1 R7 real slot0", 128'(m_data[31:16]), 128'(18));
        check(m_data[15:0] === 16'd0 && m_data[47:32] === 16'd0 &&
              m_data[79:64] === 16'd0 && m_data[111:96] === 16'd0,
              "R1 imag lanes zero", m_data, '0);
      end
    end
    hold_pend = 1; hold_data = m_data;

    // R5: full-rate streaming
    fires = 0;
    for (int n = 0; n < 200; n++) begin
      step(1, rndbeat(), 1);
      if (in_fire) fires++;
    end
    check(fires == 200, "R5 throughput", 128'(fires), 128'(200));

    // R6 R8: random valid gaps with random backpressure
    have = 0;
    for (int n = 0; n < 4000; n++) begin
      if (!have) begin
        have = ($urandom % 10) < 7;
        b = rndbeat();
      end
      step(have, b, ($urandom % 4) != 0);
      if (in_fire) have = 0;
    end

    // Drain
    for (int n = 0; n < 50 && expq.size() != 0; n++) step(0, '0, 1);
    check(expq.size() == 0, "R6 all beats out", 128'(expq.size()), '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule